// File: doc/BRIEF.md
# JTAG Scan Master with Idle-Free Resume

This block is a host-side controller for one target test access port. It generates TCK, TMS and TDI and samples TDO to perform a single instruction or data register scan per command. A command carries the scan kind, the number of bits for data scans, the bits to send, and whether the scan should finish in Run-Test/Idle or in the Pause state of the register just scanned. The bits captured from TDO come back on a result bus, and a done strobe marks the end of the scan.

The controller keeps its own copy of the target's TAP state. When a scan begins while the TAP is parked in a Pause state, the controller goes through Exit2 and Update and then straight back to Select-DR, so Run-Test/Idle is never entered. This matters because on the intended targets, passing through Idle starts an action. Idle is entered only when a command asks for it. The controller also remembers the last instruction it loaded and drops a repeated instruction scan without any TCK activity. Each TCK period lasts two system clocks. TMS and TDI change together with the falling edge of TCK, and TDO is sampled at the rising edge.

Top module: `jtag_scan_master`

## Requirements
- R1: After the asynchronous reset is released, the block issues at least five TCK pulses with TMS high, which leaves the target in Test-Logic-Reset. It then issues one pulse with TMS low, which leaves the target in Run-Test/Idle. After that, busy goes low. done does not pulse during this sequence, and TCK is low whenever busy is low.
- R2: A data scan of N bits started from Run-Test/Idle moves the target through Select-DR and Capture-DR into Shift-DR. It then shifts cmd_data[0] first, up to cmd_data[N-1]. TMS is high on the last shifted bit and low on every other shifted bit.
- R3: Bit i of rsp_data holds the i-th TDO bit sampled in the Shift state. Bits at and above the scan length are zero. done is high for exactly one clock once the end state is reached, and busy is low while done is high.
- R4: When cmd_end_idle is 0, the scan ends in Pause-DR for a data scan or Pause-IR for an instruction scan, and Run-Test/Idle is not entered.
- R5: When cmd_end_idle is 1, the scan leaves through Exit1 and Update and ends in Run-Test/Idle. This is the only time Idle is entered during the scan.
- R6: A scan started from Pause-IR that targets the instruction register visits exactly Exit2-IR, Update-IR, Select-DR, Select-IR, Capture-IR and Shift-IR before it shifts any bit.
- R7: A data scan started from Pause-DR visits exactly Exit2-DR, Update-DR, Select-DR, Capture-DR and Shift-DR before it shifts any bit.
- R8: An instruction scan (cmd_ir = 1) always shifts exactly 5 bits, taken from cmd_data[4:0]. cmd_len is ignored for instruction scans.
- R9: An instruction scan whose cmd_data[4:0] equals the last instruction loaded issues no TCK pulses. It raises done in the clock after it is accepted and returns rsp_data = 0. Reset clears the remembered instruction, so the first instruction scan after a reset is always performed.
- R10: cmd_start has no effect while busy is high. The current scan finishes with its own data, and no further TCK pulses follow it.
- R11: TMS and TDI change only together with a falling edge of TCK and stay stable while TCK is high.
- R12: Scan lengths of 1 and 64 bits work as described in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start a scan when busy is low |
| cmd_ir | input | 1 | 1 = instruction scan, 0 = data scan |
| cmd_len | input | 7 | Number of bits for a data scan (1..64) |
| cmd_data | input | 64 | Bits to shift out, LSB first |
| cmd_end_idle | input | 1 | 1 = end in Run-Test/Idle, 0 = end in Pause |
| busy | output | 1 | Reset sequence or scan in progress |
| done | output | 1 | One-clock strobe at the end of a scan |
| rsp_data | output | 64 | Captured TDO bits, LSB first |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |

## Verification
Two events can fall in the same clock: a new cmd_start and a scan that is still in flight. The bench provokes this by pulsing a start with different fields in the middle of a data scan. It then judges the outcome by checking that the shifted-in bits, the captured result, the final TAP state and the TCK pulse count all match the first command only. A second overlap is a repeated instruction that hits the cache in the same clock it is accepted. The bench drives such a command and checks that done rises in the very next clock with no TCK pulse. Finally, it resets the block and confirms that the same instruction is now shifted in full.

// File: rtl/jtm_pkg.sv
package jtm_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SELDR, TS_CAPDR, TS_SHDR, TS_EX1DR, TS_PAUDR, TS_EX2DR, TS_UPDDR,
    TS_SELIR, TS_CAPIR, TS_SHIR, TS_EX1IR, TS_PAUIR, TS_EX2IR, TS_UPDIR
  } tap_st_t;

  // Standard TAP transition for one TCK rising edge.
  function automatic tap_st_t tap_step(tap_st_t s, logic m);
    case (s)
      TS_RESET: tap_step = m ? TS_RESET : TS_IDLE;
      TS_IDLE:  tap_step = m ? TS_SELDR : TS_IDLE;
      TS_SELDR: tap_step = m ? TS_SELIR : TS_CAPDR;
      TS_CAPDR: tap_step = m ? TS_EX1DR : TS_SHDR;
      TS_SHDR:  tap_step = m ? TS_EX1DR : TS_SHDR;
      TS_EX1DR: tap_step = m ? TS_UPDDR : TS_PAUDR;
      TS_PAUDR: tap_step = m ? TS_EX2DR : TS_PAUDR;
      TS_EX2DR: tap_step = m ? TS_UPDDR : TS_SHDR;
      TS_UPDDR: tap_step = m ? TS_SELDR : TS_IDLE;
      TS_SELIR: tap_step = m ? TS_RESET : TS_CAPIR;
      TS_CAPIR: tap_step = m ? TS_EX1IR : TS_SHIR;
      TS_SHIR:  tap_step = m ? TS_EX1IR : TS_SHIR;
      TS_EX1IR: tap_step = m ? TS_UPDIR : TS_PAUIR;
      TS_PAUIR: tap_step = m ? TS_EX2IR : TS_PAUIR;
      TS_EX2IR: tap_step = m ? TS_UPDIR : TS_SHIR;
      default:  tap_step = m ? TS_SELDR : TS_IDLE;
    endcase
  endfunction

  // TMS that walks toward the Shift state of the wanted register without
  // ever stepping into Run-Test/Idle.
  function automatic logic nav_tms(tap_st_t s, logic want_ir);
    case (s)
      TS_IDLE, TS_PAUDR, TS_PAUIR, TS_EX2DR, TS_EX2IR,
      TS_UPDDR, TS_UPDIR: nav_tms = 1'b1;
      TS_SELDR:           nav_tms = want_ir;
      default:            nav_tms = 1'b0;
    endcase
  endfunction

  function automatic logic st_is_shift(tap_st_t s);
    st_is_shift = (s == TS_SHDR) || (s == TS_SHIR);
  endfunction

  function automatic logic st_is_exit1(tap_st_t s);
    st_is_exit1 = (s == TS_EX1DR) || (s == TS_EX1IR);
  endfunction

  function automatic logic st_is_update(tap_st_t s);
    st_is_update = (s == TS_UPDDR) || (s == TS_UPDIR);
  endfunction

endpackage

// File: rtl/jtm_tap_track.sv
module jtm_tap_track
  import jtm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    step,
  input  logic    tms_i,
  output tap_st_t state
);

  tap_st_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TS_RESET;
    else if (step) st_q <= tap_step(st_q, tms_i);
  end

  assign state = st_q;

endmodule

// File: rtl/jtm_ir_cache.sv
module jtm_ir_cache #(
  parameter int IRW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [IRW-1:0] code,
  output logic           hit
);

  logic           valid_q;
  logic [IRW-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      code_q  <= code;
    end
  end

  assign hit = valid_q && (code_q == code);

endmodule

// File: rtl/jtm_shifter.sv
module jtm_shifter #(
  parameter int DW = 64,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] ld_len,
  input  logic [DW-1:0] ld_data,
  input  logic          sample,
  input  logic          tdo_i,
  output logic          tdi_bit,
  output logic          last_bit,
  output logic          all_done,
  output logic [DW-1:0] rdata
);

  localparam int IXW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] data_q, rdata_q;
  logic [LW-1:0] len_q, cnt_q;

  function automatic logic is_last(logic [LW-1:0] c, logic [LW-1:0] n);
    is_last = (LW'(c + 1'b1) == n);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      rdata_q <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      data_q  <= ld_data;
      rdata_q <= '0;
      len_q   <= ld_len;
      cnt_q   <= '0;
    end else if (sample) begin
      rdata_q[cnt_q[IXW-1:0]] <= tdo_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tdi_bit  = data_q[cnt_q[IXW-1:0]];
  assign last_bit = is_last(cnt_q, len_q);
  assign all_done = (cnt_q >= len_q);
  assign rdata    = rdata_q;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len_q);

endmodule

// File: rtl/jtag_scan_master.sv
module jtag_scan_master
  import jtm_pkg::*;
#(
  parameter int DW       = 64,
  parameter int IRW      = 5,
  parameter int RST_TCKS = 5,
  localparam int LW      = $clog2(DW + 1),
  localparam int RCW     = $clog2(RST_TCKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_ir,
  input  logic [LW-1:0] cmd_len,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_end_idle,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rsp_data,
  output logic          tck,
  output logic          tms,
  output logic          tdi,
  input  logic          tdo
);

  typedef enum logic [1:0] {C_WAIT, C_FALL, C_RISE} ctl_t;

  ctl_t           ctl_q;
  logic           tck_q, tms_q, tdi_q, done_q;
  logic           seq_rst_q, is_ir_q, end_idle_q;
  logic [RCW-1:0] rcnt_q;

  tap_st_t        tap;
  logic           accept, skip, step, sample;
  logic           sh_tdi, sh_last, sh_all;
  logic           cache_hit;
  logic           more, p_tms, p_tdi;
  logic [LW-1:0]  ld_len;
  logic [DW-1:0]  ld_data;

  assign accept  = cmd_start && (ctl_q == C_WAIT);
  assign skip    = accept && cmd_ir && cache_hit;
  assign step    = (ctl_q == C_RISE);
  assign sample  = step && st_is_shift(tap) && !seq_rst_q;
  assign ld_len  = cmd_ir ? LW'(IRW) : cmd_len;
  assign ld_data = cmd_ir ? {{(DW-IRW){1'b0}}, cmd_data[IRW-1:0]} : cmd_data;

  jtm_tap_track u_tap (
    .clk(clk), .rst_n(rst_n), .step(step), .tms_i(tms_q), .state(tap)
  );

  jtm_ir_cache #(.IRW(IRW)) u_cache (
    .clk(clk), .rst_n(rst_n), .load(accept && cmd_ir),
    .code(cmd_data[IRW-1:0]), .hit(cache_hit)
  );

  jtm_shifter #(.DW(DW), .LW(LW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .ld_len(ld_len),
    .ld_data(ld_data), .sample(sample), .tdo_i(tdo), .tdi_bit(sh_tdi),
    .last_bit(sh_last), .all_done(sh_all), .rdata(rsp_data)
  );

  // Next TCK plan, evaluated at each falling step from the tracked state.
  always_comb begin
    more  = 1'b1;
    p_tms = 1'b0;
    p_tdi = 1'b0;
    if (seq_rst_q) begin
      if (rcnt_q < RCW'(RST_TCKS)) p_tms = 1'b1;
      else if (tap != TS_RESET)    more  = 1'b0;
    end else if (!sh_all) begin
      if (st_is_shift(tap)) begin
        p_tms = sh_last;
        p_tdi = sh_tdi;
      end else begin
        p_tms = nav_tms(tap, is_ir_q);
      end
    end else if (st_is_exit1(tap)) begin
      p_tms = end_idle_q;
    end else if (!st_is_update(tap)) begin
      more = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= C_FALL;
      tck_q      <= 1'b0;
      tms_q      <= 1'b1;
      tdi_q      <= 1'b0;
      done_q     <= 1'b0;
      seq_rst_q  <= 1'b1;
      rcnt_q     <= '0;
      is_ir_q    <= 1'b0;
      end_idle_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ctl_q)
        C_WAIT: if (accept) begin
          is_ir_q    <= cmd_ir;
          end_idle_q <= cmd_end_idle;
          if (skip) done_q <= 1'b1;
          else      ctl_q  <= C_FALL;
        end
        C_FALL: begin
          tck_q <= 1'b0;
          if (more) begin
            tms_q <= p_tms;
            tdi_q <= p_tdi;
            ctl_q <= C_RISE;
          end else begin
            ctl_q     <= C_WAIT;
            done_q    <= !seq_rst_q;
            seq_rst_q <= 1'b0;
          end
        end
        C_RISE: begin
          tck_q <= 1'b1;
          ctl_q <= C_FALL;
          if (seq_rst_q && rcnt_q < RCW'(RST_TCKS)) rcnt_q <= rcnt_q + 1'b1;
        end
        default: ctl_q <= C_WAIT;
      endcase
    end
  end

  assign busy = (ctl_q != C_WAIT);
  assign done = done_q;
  assign tck  = tck_q;
  assign tms  = tms_q;
  assign tdi  = tdi_q;

  assert_pins_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tck_q |-> ($stable(tms_q) && $stable(tdi_q)));

  assert_done_at_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy && !tck_q));

  assert_idle_only_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tap == TS_IDLE && $past(tap) != TS_IDLE) |-> (seq_rst_q || sh_all));

  assert_skip_no_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> (done_q && !busy && !tck_q));

  assert_busy_holds_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && busy) |=> ($stable(is_ir_q) && $stable(end_idle_q)));

endmodule

// File: tb/sim_jtag_scan_master.sv
`timescale 1ns/1ps
module sim_jtag_scan_master;

  localparam logic [3:0] K_TLR = 4'd0,  K_IDLE = 4'd1, K_SDR = 4'd2,  K_CDR = 4'd3,
                         K_SHDR = 4'd4, K_E1DR = 4'd5, K_PDR = 4'd6,  K_E2DR = 4'd7,
                         K_UDR = 4'd8,  K_SIR = 4'd9,  K_CIR = 4'd10, K_SHIR = 4'd11,
                         K_E1IR = 4'd12, K_PIR = 4'd13, K_E2IR = 4'd14, K_UIR = 4'd15;
  localparam logic [63:0] CAPB = 64'hA5C3_0F96_1E2D_7B48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_ir = 1'b0, cmd_end_idle = 1'b0;
  logic [6:0] cmd_len = 7'd0;
  logic [63:0] cmd_data = 64'd0;
  logic busy, done, tck, tms, tdi;
  logic tdo = 1'b0;
  logic [63:0] rsp_data;

  jtag_scan_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_ir(cmd_ir),
    .cmd_len(cmd_len), .cmd_data(cmd_data), .cmd_end_idle(cmd_end_idle),
    .busy(busy), .done(done), .rsp_data(rsp_data), .tck(tck), .tms(tms),
    .tdi(tdi), .tdo(tdo)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 1'b0;

  // ---------------- target TAP model ----------------
  logic [3:0]  bst = K_PDR;
  logic [63:0] sr = '0, shin = '0, pathv = '0;
  logic [4:0]  irsr = '0, ir_reg = 5'd1;
  int k = 0, tms_ones = 0, tms_idx = -1, vcount = 0, idle_n = 0, tck_n = 0;
  bit saw_tlr = 1'b0;
  int done_n = 0, viol = 0;
  logic tms_prev = 1'b1, tdi_prev = 1'b0;

  function automatic logic [3:0] bnext(logic [3:0] s, logic m);
    case (s)
      K_TLR:  return m ? K_TLR  : K_IDLE;
      K_IDLE: return m ? K_SDR  : K_IDLE;
      K_SDR:  return m ? K_SIR  : K_CDR;
      K_CDR:  return m ? K_E1DR : K_SHDR;
      K_SHDR: return m ? K_E1DR : K_SHDR;
      K_E1DR: return m ? K_UDR  : K_PDR;
      K_PDR:  return m ? K_E2DR : K_PDR;
      K_E2DR: return m ? K_UDR  : K_SHDR;
      K_UDR:  return m ? K_SDR  : K_IDLE;
      K_SIR:  return m ? K_TLR  : K_CIR;
      K_CIR:  return m ? K_E1IR : K_SHIR;
      K_SHIR: return m ? K_E1IR : K_SHIR;
      K_E1IR: return m ? K_UIR  : K_PIR;
      K_PIR:  return m ? K_E2IR : K_PIR;
      K_E2IR: return m ? K_UIR  : K_SHIR;
      default: return m ? K_SDR : K_IDLE;
    endcase
  endfunction

  always @(posedge tck) begin
    tck_n = tck_n + 1;
    case (bst)
      K_CDR: begin sr = CAPB ^ {59'd0, ir_reg}; k = 0; shin = '0; tms_ones = 0; tms_idx = -1; end
      K_CIR: begin irsr = 5'b00001; k = 0; shin = '0; tms_ones = 0; tms_idx = -1; end
      K_SHDR: begin
        shin[k[5:0]] = tdi; if (tms) begin tms_ones++; tms_idx = k; end
        k++; sr = {tdi, sr[63:1]};
      end
      K_SHIR: begin
        shin[k[5:0]] = tdi; if (tms) begin tms_ones++; tms_idx = k; end
        k++; irsr = {tdi, irsr[4:1]};
      end
      K_UIR: ir_reg = irsr;
      default: ;
    endcase
    bst = bnext(bst, tms);
    if (bst == K_TLR) begin saw_tlr = 1'b1; ir_reg = 5'd1; end
    if (bst == K_IDLE) idle_n++;
    if (vcount < 16) pathv[vcount*4 +: 4] = bst;
    vcount++;
  end

  always @(negedge tck)
    tdo = (bst == K_SHDR) ? sr[0] : (bst == K_SHIR) ? irsr[0] : 1'b0;

  // Pin discipline and done monitor, sampled away from the clock edge.
  always @(negedge clk) begin
    if (tck && (tms !== tms_prev || tdi !== tdi_prev)) viol++;
    tms_prev = tms;
    tdi_prev = tdi;
    if (done) done_n++;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lmask(int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic clear_log();
    vcount = 0; pathv = '0; idle_n = 0; tck_n = 0; done_n = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
    if (n >= 4000) chk(1'b0, "timeout busy", 64'd1, 64'd0);
  endtask

  logic [63:0] got;
  bit first_done, done_after;

  task automatic run_cmd(input logic ir, input logic [6:0] len, input logic [63:0] d, input logic eidle);
    int n = 0;
    wait_idle();
    clear_log();
    @(negedge clk);
    cmd_start = 1'b1; cmd_ir = ir; cmd_len = len; cmd_data = d; cmd_end_idle = eidle;
    @(negedge clk);
    cmd_start = 1'b0;
    first_done = done;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    if (n >= 4000) chk(1'b0, "timeout done", 64'd1, 64'd0);
    got = rsp_data;
    @(negedge clk);
    done_after = done;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    saw_tlr = 1'b0; clear_log();
    rst_n = 1'b1;
    @(negedge clk);
    wait_idle();
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    do_reset();
    chk(saw_tlr, "R1 reset reaches Test-Logic-Reset", 64'(saw_tlr), 64'd1);
    chk(bst == K_IDLE, "R1 reset ends in Idle", 64'(bst), 64'(K_IDLE));
    chk(done_n == 0 && !tck, "R1 no done and tck low", 64'(done_n), 64'd0);
    chk(tck_n >= 6, "R1 reset pulse count", 64'(tck_n), 64'd6);
  endtask

  task automatic t_dr_from_idle();
    logic [63:0] d = 64'h0000_0000_0000_0B6D;
    run_cmd(1'b0, 7'd12, d, 1'b0);
    chk(pathv[11:0] == {K_SHDR, K_CDR, K_SDR}, "R2 path from Idle", {52'd0, pathv[11:0]}, {52'd0, K_SHDR, K_CDR, K_SDR});
    chk(shin == (d & lmask(12)) && k == 12, "R2 shifted bits LSB first", shin, d & lmask(12));
    chk(tms_ones == 1 && tms_idx == 11, "R2 TMS high only on last bit", 64'(tms_idx), 64'd11);
    chk(got == ((CAPB ^ 64'd1) & lmask(12)), "R3 captured data", got, (CAPB ^ 64'd1) & lmask(12));
    chk(!done_after && !busy, "R3 done single pulse", 64'(done_after), 64'd0);
    chk(bst == K_PDR && idle_n == 0 && tck_n == 16, "R4 ends Pause-DR", 64'(bst), 64'(K_PDR));
  endtask

  task automatic t_resume_dr();
    run_cmd(1'b0, 7'd9, 64'h1A5, 1'b0);
    chk(pathv[19:0] == {K_SHDR, K_CDR, K_SDR, K_UDR, K_E2DR}, "R7 resume Pause-DR path",
        {44'd0, pathv[19:0]}, {44'd0, K_SHDR, K_CDR, K_SDR, K_UDR, K_E2DR});
    chk(idle_n == 0 && bst == K_PDR, "R7 no Idle on resume", 64'(idle_n), 64'd0);
    chk(shin == 64'h1A5, "R7 data after resume", shin, 64'h1A5);
  endtask

  task automatic t_ir_load();
    run_cmd(1'b1, 7'd40, 64'hFFFF_FFFF_FFFF_FFEA, 1'b0);
    chk(pathv[23:0] == {K_SHIR, K_CIR, K_SIR, K_SDR, K_UDR, K_E2DR}, "R8 IR path from Pause-DR",
        {40'd0, pathv[23:0]}, {40'd0, K_SHIR, K_CIR, K_SIR, K_SDR, K_UDR, K_E2DR});
    chk(k == 5 && shin == 64'h0A, "R8 five instruction bits", shin, 64'h0A);
    chk(got == 64'd1, "R8 IR capture result", got, 64'd1);
    chk(bst == K_PIR && idle_n == 0, "R4 IR ends Pause-IR", 64'(bst), 64'(K_PIR));
  endtask

  task automatic t_resume_ir();
    run_cmd(1'b1, 7'd5, 64'h13, 1'b0);
    chk(pathv[23:0] == {K_SHIR, K_CIR, K_SIR, K_SDR, K_UIR, K_E2IR}, "R6 resume Pause-IR path",
        {40'd0, pathv[23:0]}, {40'd0, K_SHIR, K_CIR, K_SIR, K_SDR, K_UIR, K_E2IR});
    chk(idle_n == 0 && ir_reg == 5'h0A, "R6 no Idle, previous IR updated", 64'(ir_reg), 64'h0A);
  endtask

  task automatic t_skip();
    run_cmd(1'b1, 7'd5, 64'h13, 1'b0);
    chk(first_done, "R9 skip done next clock", 64'(first_done), 64'd1);
    chk(tck_n == 0, "R9 skip no TCK", 64'(tck_n), 64'd0);
    chk(got == 64'd0 && bst == K_PIR, "R9 skip result zero", got, 64'd0);
  endtask

  task automatic t_end_idle();
    run_cmd(1'b0, 7'd8, 64'hC3, 1'b1);
    chk(bst == K_IDLE && idle_n == 1, "R5 ends in Idle once", 64'(idle_n), 64'd1);
    chk(vcount == 15 && pathv[59:52] == {K_IDLE, K_UDR}, "R5 exit via Update",
        {56'd0, pathv[59:52]}, {56'd0, K_IDLE, K_UDR});
    chk(got == ((CAPB ^ 64'h13) & lmask(8)) && shin == 64'hC3, "R5 data with new IR",
        got, (CAPB ^ 64'h13) & lmask(8));
  endtask

  task automatic t_len1();
    run_cmd(1'b0, 7'd1, 64'h1, 1'b0);
    chk(k == 1 && shin == 64'h1 && tms_idx == 0, "R12 one-bit scan shift", shin, 64'h1);
    chk(got == ((CAPB ^ 64'h13) & 64'h1), "R12 one-bit result", got, (CAPB ^ 64'h13) & 64'h1);
  endtask

  task automatic t_len64();
    logic [63:0] d = 64'h8123_4567_89AB_CDEF;
    run_cmd(1'b0, 7'd64, d, 1'b0);
    chk(k == 64 && shin == d && tms_idx == 63, "R12 64-bit shift", shin, d);
    chk(got == (CAPB ^ 64'h13), "R12 64-bit result", got, CAPB ^ 64'h13);
  endtask

  task automatic t_busy_ignore();
    int n = 0;
    int t_end;
    wait_idle();
    clear_log();
    @(negedge clk);
    cmd_start = 1'b1; cmd_ir = 1'b0; cmd_len = 7'd20; cmd_data = 64'h5_9E3C; cmd_end_idle = 1'b0;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (6) @(negedge clk);
    cmd_start = 1'b1; cmd_ir = 1'b1; cmd_len = 7'd3; cmd_data = 64'h1F; cmd_end_idle = 1'b1;
    repeat (3) @(negedge clk);
    cmd_start = 1'b0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    got = rsp_data;
    t_end = tck_n;
    repeat (20) @(negedge clk);
    chk(shin == 64'h5_9E3C && k == 20, "R10 first command data kept", shin, 64'h5_9E3C);
    chk(got == ((CAPB ^ 64'h13) & lmask(20)), "R10 result of first command", got, (CAPB ^ 64'h13) & lmask(20));
    chk(tck_n == t_end && bst == K_PDR && idle_n == 0, "R10 no extra scan", 64'(tck_n), 64'(t_end));
  endtask

  task automatic t_cache_reset();
    do_reset();
    chk(bst == K_IDLE, "R1 second reset to Idle", 64'(bst), 64'(K_IDLE));
    run_cmd(1'b1, 7'd5, 64'h13, 1'b0);
    chk(tck_n > 0 && k == 5 && shin == 64'h13, "R9 cache cleared by reset", 64'(tck_n), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_dr_from_idle();
    t_resume_dr();
    t_ir_load();
    t_resume_ir();
    t_skip();
    t_end_idle();
    t_len1();
    t_len64();
    t_busy_ignore();
    t_cache_reset();
    chk(viol == 0, "R11 pins stable while TCK high", 64'(viol), 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule